// File: doc/BRIEF.md
# Page Table Walker for Translation Misses

This block services a miss in a translation cache by reading a single page table entry from memory. When a miss arrives it takes the virtual page number from the request and the table base held in a base register. From the two it forms the address of the entry and issues one read on a request/grant memory port. It then inspects the returned word.

If the entry is marked present, the block offers the physical page number and the status flags to the translation cache over a valid/ready refill handshake. The cache installs the entry and retries the original access. If the entry is absent, nothing is installed. Instead a one-cycle fault pulse reports the faulting page number, so the access can be restarted once the page has been brought in.

Pages are 4 KiB. The low 12 bits of a virtual address therefore never reach this block. Only one walk is in flight at a time, and `busy` tells the requester to hold further misses.

Top module: `page_walker`

## Requirements
- R1: While reset is active and in the cycle after it is released, `busy`, `mem_req`, `refill_valid` and `fault_pulse` are all 0.
- R2: A miss accepted while idle starts a walk, and in the next cycle `mem_req` is 1. The read address is the base-register value plus four times the page number. Both values are taken in the accepting cycle, and the sum wraps modulo 2^PA_W.
- R3: `mem_req` stays at 1 with an unchanged `mem_addr` until a cycle in which `mem_gnt` is 1.
- R4: `busy` is 1 from the cycle after acceptance until the walk ends. A miss presented while busy is ignored, and the walk keeps the page number it accepted.
- R5: A returned word with bit 31 set is a present entry. It produces `refill_valid` one cycle after `mem_rvalid`, with these fields:
  - `refill_ppn` = bits 19:0
  - `refill_referenced` = bit 30
  - `refill_dirty` = bit 29
  - `refill_writable` = bit 28
  - `refill_vpn` = the page number of the walk
- R6: `refill_valid` and its fields hold steady until `refill_ready` is 1. In the cycle after that handshake, `refill_valid` and `busy` are both 0.
- R7: A returned word with bit 31 clear is an absent entry. It produces a `fault_pulse` lasting exactly one cycle, one cycle after `mem_rvalid`, with `fault_vpn` equal to the page number of the walk. `refill_valid` stays 0, and `busy` is 0 in the cycle after the pulse.
- R8: Each walk issues exactly one read: once granted, `mem_req` stays 0 until the next accepted miss.
- R9: A `mem_rvalid` that arrives while the read is still waiting for its grant is ignored. The outcome follows the word returned after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss request |
| miss_vpn | input | VPN_W | Virtual page number that missed |
| table_base | input | PA_W | Physical byte address of the page table |
| busy | output | 1 | A walk is in progress; misses are not taken |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | PA_W | Byte address of the entry being read |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | PTE_W | Entry word read from memory |
| refill_valid | output | 1 | Translation entry offered to the cache |
| refill_ready | input | 1 | Cache takes the offered entry |
| refill_vpn | output | VPN_W | Page number of the refilled translation |
| refill_ppn | output | PPN_W | Physical page number |
| refill_referenced | output | 1 | Referenced flag of the entry |
| refill_dirty | output | 1 | Dirty flag of the entry |
| refill_writable | output | 1 | Writable flag of the entry |
| fault_pulse | output | 1 | One-cycle page-fault indication |
| fault_vpn | output | VPN_W | Page number that faulted |

## Verification
The bench builds the block with its defaults: 20-bit page numbers, 20-bit physical page numbers, 32-bit addresses and 32-bit entries. Directed walks place the base near the top of the address space and use the largest page number, which forces the entry address to wrap. Other directed cases cover page number zero and absent entries whose other bits are all ones.

Random walks vary the grant, data and ready delays from zero to several cycles. Between those delays they inject stray misses and early read data, which exercises the hold and ignore behaviour of the handshakes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_READ_REQ  = 3'd1,
    ST_WAIT_DATA = 3'd2,
    ST_REFILL    = 3'd3,
    ST_FAULT     = 3'd4
  } walk_state_e;

  // Flag bit positions inside an entry word.
  localparam int BIT_PRESENT    = 31;
  localparam int BIT_REFERENCED = 30;
  localparam int BIT_DIRTY      = 29;
  localparam int BIT_WRITABLE   = 28;

  typedef struct packed {
    logic present;
    logic referenced;
    logic dirty;
    logic writable;
  } pte_flags_t;

  function automatic pte_flags_t flags_of(input logic [31:0] word);
    pte_flags_t f;
    f.present    = word[BIT_PRESENT];
    f.referenced = word[BIT_REFERENCED];
    f.dirty      = word[BIT_DIRTY];
    f.writable   = word[BIT_WRITABLE];
    return f;
  endfunction

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss_valid,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic        rd_present,
  input  logic        refill_ready,
  output walk_state_e state,
  output logic        accept,
  output logic        grant_evt,
  output logic        data_evt,
  output logic        refill_done,
  output logic        fault_evt
);

  walk_state_e state_nxt;

  assign accept      = (state == ST_IDLE) && miss_valid;
  assign grant_evt   = (state == ST_READ_REQ) && mem_gnt;
  assign data_evt    = (state == ST_WAIT_DATA) && mem_rvalid;
  assign refill_done = (state == ST_REFILL) && refill_ready;
  assign fault_evt   = (state == ST_FAULT);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:      if (accept) state_nxt = ST_READ_REQ;
      ST_READ_REQ:  if (grant_evt) state_nxt = ST_WAIT_DATA;
      ST_WAIT_DATA: if (data_evt) state_nxt = rd_present ? ST_REFILL : ST_FAULT;
      ST_REFILL:    if (refill_done) state_nxt = ST_IDLE;
      ST_FAULT:     state_nxt = ST_IDLE;
      default:      state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath #(
  parameter int VPN_W = 20,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             data_evt,
  input  logic [VPN_W-1:0] miss_vpn,
  input  logic [PA_W-1:0]  table_base,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic [VPN_W-1:0] walk_vpn,
  output logic [PA_W-1:0]  walk_addr,
  output logic [PTE_W-1:0] walk_pte
);

  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

  // Byte address of the entry: base plus page number scaled by entry size.
  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0]  base,
                                                 input logic [VPN_W-1:0] vpn);
    return base + (PA_W'(vpn) << ENTRY_SHIFT);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walk_vpn  <= '0;
      walk_addr <= '0;
      walk_pte  <= '0;
    end else begin
      if (accept) begin
        walk_vpn  <= miss_vpn;
        walk_addr <= entry_addr(table_base, miss_vpn);
      end
      if (data_evt) walk_pte <= mem_rdata;
    end
  end

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int PPN_W = 20
) (
  input  logic [PTE_W-1:0] word,
  output pte_flags_t       flags,
  output logic [PPN_W-1:0] ppn
);

  assign flags = flags_of(word[31:0]);
  assign ppn   = word[PPN_W-1:0];

endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [VPN_W-1:0] miss_vpn,
  input  logic [PA_W-1:0]  table_base,
  output logic             busy,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             refill_valid,
  input  logic             refill_ready,
  output logic [VPN_W-1:0] refill_vpn,
  output logic [PPN_W-1:0] refill_ppn,
  output logic             refill_referenced,
  output logic             refill_dirty,
  output logic             refill_writable,
  output logic             fault_pulse,
  output logic [VPN_W-1:0] fault_vpn
);

  walk_state_e      state;
  logic             accept, grant_evt, data_evt, refill_done, fault_evt;
  logic             rd_present;
  pte_flags_t       rd_flags, walk_flags;
  logic [PPN_W-1:0] rd_ppn_unused_free, walk_ppn;
  logic [VPN_W-1:0] walk_vpn;
  logic [PA_W-1:0]  walk_addr;
  logic [PTE_W-1:0] walk_pte;

  ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_rd_dec (
    .word  (mem_rdata),
    .flags (rd_flags),
    .ppn   (rd_ppn_unused_free)
  );
  assign rd_present = rd_flags.present;

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .mem_gnt      (mem_gnt),
    .mem_rvalid   (mem_rvalid),
    .rd_present   (rd_present),
    .refill_ready (refill_ready),
    .state        (state),
    .accept       (accept),
    .grant_evt    (grant_evt),
    .data_evt     (data_evt),
    .refill_done  (refill_done),
    .fault_evt    (fault_evt)
  );

  ptw_datapath #(.VPN_W(VPN_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .data_evt   (data_evt),
    .miss_vpn   (miss_vpn),
    .table_base (table_base),
    .mem_rdata  (mem_rdata),
    .walk_vpn   (walk_vpn),
    .walk_addr  (walk_addr),
    .walk_pte   (walk_pte)
  );

  ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_walk_dec (
    .word  (walk_pte),
    .flags (walk_flags),
    .ppn   (walk_ppn)
  );

  assign busy              = (state != ST_IDLE);
  assign mem_req           = (state == ST_READ_REQ);
  assign mem_addr          = walk_addr;
  assign refill_valid      = (state == ST_REFILL);
  assign refill_vpn        = walk_vpn;
  assign refill_ppn        = walk_ppn;
  assign refill_referenced = walk_flags.referenced;
  assign refill_dirty      = walk_flags.dirty;
  assign refill_writable   = walk_flags.writable;
  assign fault_pulse       = fault_evt;
  assign fault_vpn         = walk_vpn;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_req,
  input logic [PA_W-1:0]  mem_addr,
  input logic             mem_gnt,
  input logic             refill_valid,
  input logic             refill_ready,
  input logic [VPN_W-1:0] refill_vpn,
  input logic [PPN_W-1:0] refill_ppn,
  input logic             fault_pulse,
  input logic             accept,
  input logic             grant_evt,
  input logic             data_evt,
  input logic             rd_present
);

  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_req && busy); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R3

  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || refill_valid || fault_pulse) |-> busy); // R4

  AST_REFILL_ON_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && rd_present) |=> refill_valid); // R5

  AST_REFILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && !refill_ready) |=>
      (refill_valid && $stable(refill_ppn) && $stable(refill_vpn))); // R6

  AST_IDLE_AFTER_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && refill_ready) |=> !busy); // R6

  AST_FAULT_ON_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && !rd_present) |=> fault_pulse); // R7

  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> (!fault_pulse && !busy)); // R7

  AST_FAULT_NOT_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_pulse && refill_valid)); // R7

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |=> !mem_req); // R8

endmodule

bind page_walker ptw_checker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .PA_W(PA_W)) u_ptw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_gnt      (mem_gnt),
  .refill_valid (refill_valid),
  .refill_ready (refill_ready),
  .refill_vpn   (refill_vpn),
  .refill_ppn   (refill_ppn),
  .fault_pulse  (fault_pulse),
  .accept       (accept),
  .grant_evt    (grant_evt),
  .data_evt     (data_evt),
  .rd_present   (rd_present)
);

// File: tb/page_walker_bench.sv
module page_walker_bench;

  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int PA_W  = 32;
  localparam int PTE_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             miss_valid = 1'b0;
  logic [VPN_W-1:0] miss_vpn = '0;
  logic [PA_W-1:0]  table_base = '0;
  logic             busy, mem_req;
  logic [PA_W-1:0]  mem_addr;
  logic             mem_gnt = 1'b0;
  logic             mem_rvalid = 1'b0;
  logic [PTE_W-1:0] mem_rdata = '0;
  logic             refill_valid;
  logic             refill_ready = 1'b0;
  logic [VPN_W-1:0] refill_vpn, fault_vpn;
  logic [PPN_W-1:0] refill_ppn;
  logic             refill_referenced, refill_dirty, refill_writable, fault_pulse;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  page_walker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_page_walker (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
    .table_base(table_base), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .refill_valid(refill_valid), .refill_ready(refill_ready), .refill_vpn(refill_vpn),
    .refill_ppn(refill_ppn), .refill_referenced(refill_referenced),
    .refill_dirty(refill_dirty), .refill_writable(refill_writable),
    .fault_pulse(fault_pulse), .fault_vpn(fault_vpn)
  );

  function automatic logic [31:0] want_addr(input logic [31:0] base, input logic [19:0] vpn);
    logic [31:0] scaled;
    scaled = {10'd0, vpn, 2'b00};
    return base + scaled;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic walk(input logic [19:0] vpn, input logic [31:0] base, input logic [31:0] pte,
                      input int gnt_dly, input int data_dly, input int rdy_dly);
    logic [31:0] ea;
    ea = want_addr(base, vpn);
    @(negedge clk);
    miss_valid = 1'b1; miss_vpn = vpn; table_base = base;
    @(negedge clk);
    chk(busy === 1'b1, "R4 busy after accept", 64'(busy), 64'd1);
    chk(mem_req === 1'b1, "R2 request raised", 64'(mem_req), 64'd1);
    chk(mem_addr === ea, "R2 entry address", 64'(mem_addr), 64'(ea));
    // stray miss and early data while waiting for grant
    miss_vpn = ~vpn; table_base = ~base;
    for (int i = 0; i < gnt_dly; i++) begin
      mem_rvalid = 1'b1; mem_rdata = ~pte;
      @(negedge clk);
      chk(mem_req === 1'b1 && mem_addr === ea, "R3 request held",
          64'({mem_req, mem_addr}), 64'({1'b1, ea}));
    end
    mem_rvalid = 1'b0; miss_valid = 1'b0;
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    chk(mem_req === 1'b0, "R8 one read per walk", 64'(mem_req), 64'd0);
    for (int i = 0; i < data_dly; i++) begin
      @(negedge clk);
      chk(mem_req === 1'b0 && busy === 1'b1, "R8 no second read",
          64'({mem_req, busy}), 64'b01);
    end
    mem_rvalid = 1'b1; mem_rdata = pte;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = ~pte;
    if (pte[31]) begin
      chk(refill_valid === 1'b1 && fault_pulse === 1'b0, "R5/R9 refill offered",
          64'({refill_valid, fault_pulse}), 64'b10);
      chk(refill_ppn === pte[19:0], "R5 ppn", 64'(refill_ppn), 64'(pte[19:0]));
      chk({refill_referenced, refill_dirty, refill_writable} === pte[30:28], "R5 flags",
          64'({refill_referenced, refill_dirty, refill_writable}), 64'(pte[30:28]));
      chk(refill_vpn === vpn, "R4/R5 walk vpn kept", 64'(refill_vpn), 64'(vpn));
      for (int i = 0; i < rdy_dly; i++) begin
        @(negedge clk);
        chk(refill_valid === 1'b1 && refill_ppn === pte[19:0], "R6 refill held",
            64'({refill_valid, refill_ppn}), 64'({1'b1, pte[19:0]}));
      end
      refill_ready = 1'b1;
      @(negedge clk);
      refill_ready = 1'b0;
      chk(refill_valid === 1'b0 && busy === 1'b0, "R6 idle after handshake",
          64'({refill_valid, busy}), 64'b00);
    end else begin
      chk(fault_pulse === 1'b1 && refill_valid === 1'b0, "R7/R9 fault raised",
          64'({fault_pulse, refill_valid}), 64'b10);
      chk(fault_vpn === vpn, "R7 fault vpn", 64'(fault_vpn), 64'(vpn));
      @(negedge clk);
      chk(fault_pulse === 1'b0 && busy === 1'b0 && refill_valid === 1'b0, "R7 single pulse",
          64'({fault_pulse, busy, refill_valid}), 64'b000);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    miss_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, mem_req, refill_valid, fault_pulse} === 4'b0, "R1 reset state",
        64'({busy, mem_req, refill_valid, fault_pulse}), 64'd0);
    miss_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, mem_req, refill_valid, fault_pulse} === 4'b0, "R1 after release",
        64'({busy, mem_req, refill_valid, fault_pulse}), 64'd0);

    // directed corners
    walk(20'h00000, 32'h0010_0000, 32'hF00A_BCDE, 0, 0, 0);
    walk(20'hFFFFF, 32'hFFFF_F000, 32'h8001_2345, 2, 1, 3);   // address wraps
    walk(20'h12345, 32'h0000_0004, 32'h7FFF_FFFF, 3, 2, 0);   // absent, all else set
    walk(20'h00001, 32'h8000_0000, 32'h0000_0000, 0, 0, 0);   // absent, zero
    walk(20'hABCDE, 32'h0123_4560, 32'hA000_0001, 1, 0, 5);

    for (int n = 0; n < 300; n++) begin
      logic [31:0] pte;
      pte = $urandom();
      walk(20'($urandom()), $urandom(), pte, $urandom_range(0, 4),
           $urandom_range(0, 4), $urandom_range(0, 4));
    end

    summary();
    $finish;
  end

endmodule